// File: doc/BRIEF.md
# Bus Read Cache-Fill Qualifier

This block watches the cycles of a 16-bit external bus and decides, for each completed read, whether the word returned on the data bus is written into an on-chip cache. When a read qualifies, it raises a one-clock fill strobe. The strobe carries the word address, the data and the byte lanes to write.

A read qualifies only if all of these hold:
- it is an unlocked memory read;
- its address lies outside every valid exclusion region;
- the external cache-enable pin, when a configuration bit makes that pin count, was high at the clock edge just before the edge where ready is sampled active.

The cycle kind, address, byte enables and exclusion result are captured when the cycle starts. A pipelined next address issued before the current ready therefore cannot change the decision for the cycle in flight. Software programs the exclusion regions and the gate bit through simple write ports. A reset clears all of them.

Top module: `rdfill_qual`

## Requirements
- R1: A write cycle (`cyc_write`=1), an I/O cycle (`cyc_mem`=0) or a locked cycle (`cyc_lock`=1) never raises `fill_stb`.
- R2: With the gate bit clear, an unlocked memory read outside all exclusion regions raises `fill_stb`, whatever `ext_cache_en` does. `fill_be` then equals the byte enables captured at cycle start (bit 0 = low byte, bit 1 = high byte).
- R3: A read whose word address A matches a valid exclusion region never fills, whatever the gate bit or the pin. Region i matches when ((A xor base_i) and mask_i) == 0.
- R4: With the gate bit set, a read fills only if `ext_cache_en` was high at the edge one clock before the edge where `bus_ready` is sampled high. The pin's value at any other edge of the cycle, including the ready edge, has no effect.
- R5: When the gate bit is set and the pin sample is high, `fill_be` is 2'b11 whatever the captured byte enables are.
- R6: `fill_stb` is high only in the clock where `bus_ready` is sampled high for an active cycle, once per cycle. `fill_addr` is the address captured at cycle start, and `fill_data` is `bus_data` in that clock.
- R7: A cycle start issued while a cycle is still active, or in the same clock as its ready, leaves the active cycle's decision and address unchanged. The new cycle is qualified on its own ready.
- R8: Reset clears the gate bit and all exclusion regions, so afterwards a read in a formerly excluded range fills with the pin low.
- R9: A region written with its valid bit clear never blocks a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | New bus cycle: address and cycle kind are valid this clock |
| cyc_addr | input | 23 | Word address of the starting cycle |
| cyc_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_lock | input | 1 | 1 = locked cycle |
| cyc_be | input | 2 | Byte enables of the starting cycle (bit 1 high byte) |
| bus_ready | input | 1 | Ready: the active cycle ends on this clock |
| bus_data | input | 16 | Read data on the bus |
| ext_cache_en | input | 1 | External per-cycle cache enable, active high |
| excl_we | input | 1 | Write strobe for one exclusion region |
| excl_idx | input | 2 | Region selected for writing |
| excl_base | input | 23 | Region base word address |
| excl_mask | input | 23 | Region compare mask (1 = bit compared) |
| excl_valid | input | 1 | Region valid bit |
| cfg_we | input | 1 | Write strobe for the gate bit |
| cfg_pin_gate | input | 1 | New gate bit value: 1 = honour `ext_cache_en` |
| fill_stb | output | 1 | Cache fill strobe |
| fill_addr | output | 23 | Word address to fill |
| fill_data | output | 16 | Data to fill |
| fill_be | output | 2 | Byte lanes to write |

## Verification
Reads are issued with zero, one and several wait states. The pin pattern differs between the early clocks, the clock before ready and the ready clock itself. These runs separate sampling one clock before ready from sampling with the data or at cycle start. Cycle kinds are swept across write, I/O and locked, and addresses are placed inside and outside valid and invalid regions, so each blocking term is shown to act alone. Both pipelined forms are used: a start during wait states and a start coincident with ready. They show that the captured context, not the current bus, drives the decision.

// File: rtl/rdfq_pkg.sv
package rdfq_pkg;

  // Kind of the cycle captured at its start
  typedef struct packed {
    logic is_mem;
    logic is_wr;
    logic locked;
    logic nc_hit;
  } cyc_kind_t;

  // Memory read, not locked, not in an excluded region
  function automatic logic kind_cacheable(input cyc_kind_t k);
    return k.is_mem && !k.is_wr && !k.locked && !k.nc_hit;
  endfunction

  // The pin only matters when the gate bit is set
  function automatic logic pin_allows(input logic gate, input logic sample);
    return !gate || sample;
  endfunction

  // Masked compare, operands zero-extended to 32 bits
  function automatic logic masked_eq(input logic [31:0] a, input logic [31:0] b,
                                     input logic [31:0] m);
    return ((a ^ b) & m) == 32'd0;
  endfunction

endpackage

// File: rtl/rdfq_region_file.sv
module rdfq_region_file #(
  parameter int ADDR_W = 23,
  parameter int N_REG  = 4,
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_mask,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              hit_any
);
  import rdfq_pkg::*;

  logic [N_REG-1:0] hit_vec;

  for (genvar g = 0; g < N_REG; g++) begin : g_region
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] mask_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q  <= '0;
        mask_q  <= '0;
        valid_q <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        base_q  <= wr_base;
        mask_q  <= wr_mask;
        valid_q <= wr_valid;
      end
    end

    assign hit_vec[g] = valid_q &&
                        masked_eq(32'(lookup_addr), 32'(base_q), 32'(mask_q));
  end

  assign hit_any = |hit_vec;

endmodule

// File: rtl/rdfq_cycle_track.sv
module rdfq_cycle_track #(
  parameter int ADDR_W = 23,
  parameter int BE_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    start_addr,
  input  rdfq_pkg::cyc_kind_t  start_kind,
  input  logic [BE_W-1:0]      start_be,
  input  logic                 ready,
  output logic                 act_v,
  output logic [ADDR_W-1:0]    act_addr,
  output rdfq_pkg::cyc_kind_t  act_kind,
  output logic [BE_W-1:0]      act_be
);
  import rdfq_pkg::*;

  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  cyc_kind_t         pend_kind;
  logic [BE_W-1:0]   pend_be;

  // The active slot frees up when idle or when its ready arrives
  logic take;
  assign take = !act_v || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_v    <= 1'b0;
      act_addr <= '0;
      act_kind <= '0;
      act_be   <= '0;
    end else if (take) begin
      if (pend_v) begin
        act_v    <= 1'b1;
        act_addr <= pend_addr;
        act_kind <= pend_kind;
        act_be   <= pend_be;
      end else if (start) begin
        act_v    <= 1'b1;
        act_addr <= start_addr;
        act_kind <= start_kind;
        act_be   <= start_be;
      end else begin
        act_v    <= 1'b0;
      end
    end
  end

  // A start that cannot go straight to the active slot waits here
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_kind <= '0;
      pend_be   <= '0;
    end else if (start && !(take && !pend_v)) begin
      pend_v    <= 1'b1;
      pend_addr <= start_addr;
      pend_kind <= start_kind;
      pend_be   <= start_be;
    end else if (take && pend_v) begin
      pend_v    <= 1'b0;
    end
  end

endmodule

// File: rtl/rdfq_decide.sv
module rdfq_decide #(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_cen,
  input  logic                 pin_gate,
  input  logic                 act_v,
  input  logic [ADDR_W-1:0]    act_addr,
  input  rdfq_pkg::cyc_kind_t  act_kind,
  input  logic [BE_W-1:0]      act_be,
  input  logic                 ready,
  input  logic [DATA_W-1:0]    data,
  output logic                 fill_stb,
  output logic [ADDR_W-1:0]    fill_addr,
  output logic [DATA_W-1:0]    fill_data,
  output logic [BE_W-1:0]      fill_be
);
  import rdfq_pkg::*;

  // Pin value at the previous edge: on the ready clock this is the
  // sample taken one clock before ready
  logic cen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) cen_q <= 1'b0;
    else        cen_q <= ext_cen;
  end

  logic pin_full;
  assign pin_full  = pin_gate && cen_q;

  assign fill_stb  = act_v && ready && kind_cacheable(act_kind) &&
                     pin_allows(pin_gate, cen_q);
  assign fill_addr = act_addr;
  assign fill_data = data;
  assign fill_be   = pin_full ? {BE_W{1'b1}} : act_be;

endmodule

// File: rtl/rdfill_qual.sv
module rdfill_qual #(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int N_REG  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_mem,
  input  logic              cyc_write,
  input  logic              cyc_lock,
  input  logic [BE_W-1:0]   cyc_be,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              ext_cache_en,
  input  logic              excl_we,
  input  logic [IDX_W-1:0]  excl_idx,
  input  logic [ADDR_W-1:0] excl_base,
  input  logic [ADDR_W-1:0] excl_mask,
  input  logic              excl_valid,
  input  logic              cfg_we,
  input  logic              cfg_pin_gate,
  output logic              fill_stb,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic [BE_W-1:0]   fill_be
);
  import rdfq_pkg::*;

  // Gate bit for the external pin
  logic pin_gate;
  always_ff @(posedge clk) begin
    if (!rst_n)      pin_gate <= 1'b0;
    else if (cfg_we) pin_gate <= cfg_pin_gate;
  end

  // Exclusion lookup on the address of the starting cycle
  logic nc_hit;
  rdfq_region_file #(.ADDR_W(ADDR_W), .N_REG(N_REG)) u_regions (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (excl_we),
    .wr_idx      (excl_idx),
    .wr_base     (excl_base),
    .wr_mask     (excl_mask),
    .wr_valid    (excl_valid),
    .lookup_addr (cyc_addr),
    .hit_any     (nc_hit)
  );

  cyc_kind_t start_kind;
  always_comb begin
    start_kind.is_mem = cyc_mem;
    start_kind.is_wr  = cyc_write;
    start_kind.locked = cyc_lock;
    start_kind.nc_hit = nc_hit;
  end

  // Captured context of the cycle in flight
  logic              act_v;
  logic [ADDR_W-1:0] act_addr;
  cyc_kind_t         act_kind;
  logic [BE_W-1:0]   act_be;

  rdfq_cycle_track #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cyc_start),
    .start_addr (cyc_addr),
    .start_kind (start_kind),
    .start_be   (cyc_be),
    .ready      (bus_ready),
    .act_v      (act_v),
    .act_addr   (act_addr),
    .act_kind   (act_kind),
    .act_be     (act_be)
  );

  rdfq_decide #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_decide (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_cen   (ext_cache_en),
    .pin_gate  (pin_gate),
    .act_v     (act_v),
    .act_addr  (act_addr),
    .act_kind  (act_kind),
    .act_be    (act_be),
    .ready     (bus_ready),
    .data      (bus_data),
    .fill_stb  (fill_stb),
    .fill_addr (fill_addr),
    .fill_data (fill_data),
    .fill_be   (fill_be)
  );

  // Named event wires for the checker
  logic act_mem, act_wr, act_lock, act_nc;
  assign act_mem  = act_kind.is_mem;
  assign act_wr   = act_kind.is_wr;
  assign act_lock = act_kind.locked;
  assign act_nc   = act_kind.nc_hit;

endmodule

// File: rtl/rdfill_qual_chk.sv
module rdfill_qual_chk #(
  parameter int ADDR_W = 23,
  parameter int BE_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ready,
  input logic              ext_cache_en,
  input logic              fill_stb,
  input logic [BE_W-1:0]   fill_be,
  input logic              pin_gate,
  input logic              act_v,
  input logic [ADDR_W-1:0] act_addr,
  input logic              act_mem,
  input logic              act_wr,
  input logic              act_lock,
  input logic              act_nc
);

  // R6
  fill_at_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_stb |-> (bus_ready && act_v));

  // R1
  fill_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_stb |-> (act_mem && !act_wr && !act_lock));

  // R3
  fill_not_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_stb |-> !act_nc);

  // R4
  pin_sampled_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_stb && pin_gate) |-> $past(ext_cache_en));

  // R5
  both_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_stb && pin_gate) |-> (fill_be == {BE_W{1'b1}}));

  // R7
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_v && $past(act_v) && !$past(bus_ready)) |-> $stable(act_addr));

endmodule

bind rdfill_qual rdfill_qual_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_ready    (bus_ready),
  .ext_cache_en (ext_cache_en),
  .fill_stb     (fill_stb),
  .fill_be      (fill_be),
  .pin_gate     (pin_gate),
  .act_v        (act_v),
  .act_addr     (act_addr),
  .act_mem      (act_mem),
  .act_wr       (act_wr),
  .act_lock     (act_lock),
  .act_nc       (act_nc)
);

// File: tb/sim_rdfill_qual.sv
module sim_rdfill_qual;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_start = 1'b0;
  logic [22:0] cyc_addr = '0;
  logic        cyc_mem = 1'b0, cyc_write = 1'b0, cyc_lock = 1'b0;
  logic [1:0]  cyc_be = '0;
  logic        bus_ready = 1'b0;
  logic [15:0] bus_data = '0;
  logic        ext_cache_en = 1'b0;
  logic        excl_we = 1'b0;
  logic [1:0]  excl_idx = '0;
  logic [22:0] excl_base = '0, excl_mask = '0;
  logic        excl_valid = 1'b0;
  logic        cfg_we = 1'b0, cfg_pin_gate = 1'b0;
  logic        fill_stb;
  logic [22:0] fill_addr;
  logic [15:0] fill_data;
  logic [1:0]  fill_be;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  rdfill_qual u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
    .cyc_mem(cyc_mem), .cyc_write(cyc_write), .cyc_lock(cyc_lock), .cyc_be(cyc_be),
    .bus_ready(bus_ready), .bus_data(bus_data), .ext_cache_en(ext_cache_en),
    .excl_we(excl_we), .excl_idx(excl_idx), .excl_base(excl_base),
    .excl_mask(excl_mask), .excl_valid(excl_valid), .cfg_we(cfg_we),
    .cfg_pin_gate(cfg_pin_gate), .fill_stb(fill_stb), .fill_addr(fill_addr),
    .fill_data(fill_data), .fill_be(fill_be)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cyc_start = 1'b0; bus_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_gate(input logic g);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pin_gate = g;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog_region(input logic [1:0] idx, input logic [22:0] b,
                             input logic [22:0] m, input logic v);
    @(negedge clk);
    excl_we = 1'b1; excl_idx = idx; excl_base = b; excl_mask = m; excl_valid = v;
    @(negedge clk);
    excl_we = 1'b0;
  endtask

  // One bus cycle; cen_final is the pin level at the edge before ready
  task automatic do_read(input string tag, input logic [22:0] a, input logic mem,
                         input logic wr, input logic lk, input logic [1:0] be,
                         input logic [15:0] d, input int waits,
                         input logic cen_early, input logic cen_final,
                         input logic exp_fill, input logic [1:0] exp_be);
    @(negedge clk);
    cyc_start = 1'b1; cyc_addr = a; cyc_mem = mem; cyc_write = wr; cyc_lock = lk;
    cyc_be = be; bus_ready = 1'b0;
    ext_cache_en = (waits == 0) ? cen_final : cen_early;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      cyc_start = 1'b0;
      cyc_addr = ~a; cyc_write = ~wr; cyc_be = ~be;
      ext_cache_en = (i == waits - 1) ? cen_final : cen_early;
      #1 chk({tag, " R6 no strobe in wait"}, {31'd0, fill_stb}, 32'd0);
    end
    @(negedge clk);
    cyc_start = 1'b0; cyc_addr = ~a; cyc_write = ~wr; cyc_be = ~be;
    bus_ready = 1'b1; bus_data = d; ext_cache_en = ~cen_final;
    #1;
    chk({tag, " strobe"}, {31'd0, fill_stb}, {31'd0, exp_fill});
    if (exp_fill) begin
      chk({tag, " R6 addr"}, {9'd0, fill_addr}, {9'd0, a});
      chk({tag, " R6 data"}, {16'd0, fill_data}, {16'd0, d});
      chk({tag, " be"}, {30'd0, fill_be}, {30'd0, exp_be});
    end
    @(negedge clk);
    bus_ready = 1'b0;
    #1 chk({tag, " R6 single pulse"}, {31'd0, fill_stb}, 32'd0);
  endtask

  task automatic t_reset_state();
    chk("R8 reset strobe low", {31'd0, fill_stb}, 32'd0);
  endtask

  task automatic t_default_fill();
    do_read("R2 gate off pin low", 23'h000123, 1, 0, 0, 2'b01, 16'hBEEF, 0, 0, 0, 1, 2'b01);
    do_read("R2 gate off waits", 23'h000456, 1, 0, 0, 2'b10, 16'h1234, 2, 0, 0, 1, 2'b10);
  endtask

  task automatic t_kinds();
    do_read("R1 write", 23'h000200, 1, 1, 0, 2'b11, 16'h1111, 1, 1, 1, 0, 2'b11);
    do_read("R1 io read", 23'h000201, 0, 0, 0, 2'b11, 16'h2222, 0, 1, 1, 0, 2'b11);
    do_read("R1 locked read", 23'h000202, 1, 0, 1, 2'b11, 16'h3333, 1, 1, 1, 0, 2'b11);
  endtask

  task automatic t_pin_timing();
    set_gate(1'b1);
    do_read("R5 pin high bytes", 23'h000300, 1, 0, 0, 2'b10, 16'hA5A5, 0, 1, 1, 1, 2'b11);
    do_read("R4 early high final low", 23'h000301, 1, 0, 0, 2'b11, 16'h5A5A, 3, 1, 0, 0, 2'b11);
    do_read("R4 early low final high", 23'h000302, 1, 0, 0, 2'b01, 16'hC3C3, 3, 0, 1, 1, 2'b11);
    do_read("R4 zero wait pin low", 23'h000303, 1, 0, 0, 2'b11, 16'h0F0F, 0, 0, 0, 0, 2'b11);
  endtask

  task automatic t_regions();
    // Region 2 covers word addresses 0x010000..0x0100FF
    prog_region(2'd2, 23'h010000, 23'h7FFF00, 1'b1);
    do_read("R3 gate on in region", 23'h010040, 1, 0, 0, 2'b11, 16'h7777, 1, 1, 1, 0, 2'b11);
    do_read("R3 just above region", 23'h010100, 1, 0, 0, 2'b11, 16'h7778, 1, 1, 1, 1, 2'b11);
    set_gate(1'b0);
    do_read("R3 gate off in region", 23'h0100FF, 1, 0, 0, 2'b11, 16'h7779, 0, 1, 1, 0, 2'b11);
    prog_region(2'd1, 23'h020000, 23'h7FFF00, 1'b0);
    do_read("R9 invalid region", 23'h020010, 1, 0, 0, 2'b01, 16'h8888, 0, 0, 0, 1, 2'b01);
  endtask

  task automatic t_pipelined();
    // Next start during the wait state of the first cycle
    @(negedge clk);
    ext_cache_en = 1'b1;
    cyc_start = 1'b1; cyc_addr = 23'h000500; cyc_mem = 1; cyc_write = 0; cyc_lock = 0; cyc_be = 2'b01;
    @(negedge clk);
    cyc_addr = 23'h000600; cyc_write = 1; cyc_be = 2'b10;
    @(negedge clk);
    cyc_start = 1'b0; cyc_addr = 23'h0; bus_ready = 1'b1; bus_data = 16'h5151;
    #1;
    chk("R7 first strobe", {31'd0, fill_stb}, 32'd1);
    chk("R7 first addr", {9'd0, fill_addr}, 32'h000500);
    chk("R7 first be", {30'd0, fill_be}, 32'd1);
    @(negedge clk);
    bus_data = 16'h6161;
    #1 chk("R7 queued write no fill", {31'd0, fill_stb}, 32'd0);
    @(negedge clk);
    bus_ready = 1'b0;
    // Next start in the same clock as ready
    @(negedge clk);
    cyc_start = 1'b1; cyc_addr = 23'h000700; cyc_write = 0; cyc_be = 2'b11;
    @(negedge clk);
    cyc_addr = 23'h010010; bus_ready = 1'b1; bus_data = 16'h7171;
    #1;
    chk("R7 overlap first strobe", {31'd0, fill_stb}, 32'd1);
    chk("R7 overlap first addr", {9'd0, fill_addr}, 32'h000700);
    @(negedge clk);
    cyc_start = 1'b0; cyc_addr = 23'h000700; bus_data = 16'h8181;
    #1 chk("R7 overlap second excluded", {31'd0, fill_stb}, 32'd0);
    @(negedge clk);
    bus_ready = 1'b0;
  endtask

  task automatic t_reset_clears();
    set_gate(1'b1);
    do_reset();
    do_read("R8 region cleared", 23'h010040, 1, 0, 0, 2'b10, 16'h9999, 1, 0, 0, 1, 2'b10);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1 t_reset_state();
    do_reset();
    t_default_fill();
    t_kinds();
    t_pin_timing();
    t_regions();
    t_pipelined();
    t_reset_clears();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

endmodule